// File: doc/BRIEF.md
# SD Error-Detection Packet Inserter

This block sits in a 10-bit standard-definition component video path. It runs two CRC-16 accumulators over each field. The full-field accumulator runs while the full-field window input is high. The active-picture accumulator runs while the active-picture window input is high. At the end of each field the block latches both results. On the line marked for insertion, it overwrites horizontal-blanking samples with a 23-word error-detection ancillary packet. That packet carries the two latched CRCs and three groups of five error flags.

The packet is placed backwards from the SAV. Its start sample is the SAV position of the line minus the packet length, so the checksum falls on the sample just before the first SAV word. The flag groups come from one of two sources, chosen by a mode input. In one mode they are taken from host-driven flag inputs. In the other they are copied from the last error-detection packet found in the incoming stream.

External logic supplies the position inputs: sample counter, SAV position, window strobes and the insertion-line marker. The host guarantees that the blanking interval has room for the packet.

Top module: `edh_inserter`

## Requirements
- R1: After reset, data_o and vld_o are 0. Both latched CRCs are 0 with their valid bits clear, until the first field_end_i.
- R2: data_o equals the data_i of the previous cycle, and vld_o equals the previous vld_i. The only exception is a sample overwritten by the packet.
- R3: Overwriting happens only when proc_en_i, bypass_i and sd_sel_i are all 1 and ins_dis_i is 0. Otherwise the insertion line passes through unchanged.
- R4: On a sample with vld_i=1 and ins_line_i=1, packet word k replaces the sample at hcnt_i = sav_pos_i - 23 + k, for k = 0..22. Word 22, the checksum, lands at sav_pos_i - 1.
- R5: Packet words 0..5 are 0x000, 0x3FF, 0x3FF, 0x1F4, 0x200, 0x110. User words 9..15 (packet words 15..21) are 0x200.
- R6: Each CRC uses polynomial x^16+x^12+x^5+1 with a zero start value. Each 10-bit word enters LSB first, when vld_i and the CRC's window are both 1, whether or not insertion is enabled.
- R7: A field_end_i pulse copies both CRCs into the latched values, sets the valid bits and clears the accumulators. A word presented with field_end_i is not accumulated. The packet carries the latched values.
- R8: User words 0..2 carry the active-picture CRC, and user words 3..5 carry the full-field CRC. Bits [7:2] of the first word hold crc[5:0], and bits [7:2] of the second hold crc[11:6]. The third word holds crc[15:12] in bits [5:2], 0 in bit 6 and the valid bit in bit 7.
- R9: User words 6, 7 and 8 carry the ancillary, full-field and active-picture flag groups in bits [6:2]: EDH in bit 2, EDA in 3, IDH in 4, IDA in 5 and UES in 6. Bit 7 is 0. With upd_mode_i=0 the groups are anc_flags_i, ff_flags_i and ap_flags_i, with flag bit 0 = EDH up to bit 4 = UES.
- R10: With upd_mode_i=1 the groups are bits [6:2] of the incoming words at offsets 9, 10 and 11 after an incoming 0x000,0x3FF,0x3FF,0x1F4 sequence, where 0x1F4 is offset 0. flags_o is {anc, ff, ap} of the selected source.
- R11: In every word from 3 to 21, bits [7:0] are the payload. Bit 8 makes bits [8:0] hold an even number of ones, and bit 9 is the inverse of bit 8.
- R12: Word 22 is the 9-bit sum of bits [8:0] of words 3..21, with bit 9 the inverse of bit 8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| vld_i | input | 1 | Sample valid strobe |
| data_i | input | 10 | Incoming video word |
| hcnt_i | input | HW | Sample position within the line |
| sav_pos_i | input | HW | Position of the first SAV word on this line |
| ins_line_i | input | 1 | Current line is the packet line |
| ff_win_i | input | 1 | Full-field CRC window |
| ap_win_i | input | 1 | Active-picture CRC window |
| field_end_i | input | 1 | End-of-field latch pulse |
| proc_en_i | input | 1 | Processing enable |
| bypass_i | input | 1 | Standards-bypass input, must be 1 |
| sd_sel_i | input | 1 | SD rate select |
| ins_dis_i | input | 1 | Insertion disable control bit |
| upd_mode_i | input | 1 | 1: pass incoming flags, 0: host flags |
| anc_flags_i | input | 5 | Host ancillary flag group |
| ff_flags_i | input | 5 | Host full-field flag group |
| ap_flags_i | input | 5 | Host active-picture flag group |
| data_o | output | 10 | Outgoing video word |
| vld_o | output | 1 | Delayed sample valid |
| flags_o | output | 15 | Flag groups in use, {anc, ff, ap} |

## Verification
The hardest case to reach is a packet whose CRC fields hold real values with the valid bits set. That needs a full field of windowed words, then a field_end_i pulse, then a whole second field before the insertion line appears. Every scenario therefore drives multi-line fields back to back, tracks both CRCs in a bench model, and compares all 23 inserted words on each insertion line. Pass-through mode also needs a well-formed incoming packet earlier in the same field. It is placed in the blanking after the SAV of the field's first line, with distinct flag values in each field.

// File: rtl/edh_pkg.sv
package edh_pkg;
  localparam int WORD_W  = 10;
  localparam int CRC_W   = 16;
  localparam int PKT_LEN = 23;
  localparam int IDX_W   = 5;
  localparam logic [WORD_W-1:0] DID_W  = 10'h1F4;
  localparam logic [WORD_W-1:0] DBN_W  = 10'h200;
  localparam logic [WORD_W-1:0] DC_W   = 10'h110;
  localparam logic [WORD_W-1:0] RSV_W  = 10'h200;

  function automatic logic [CRC_W-1:0] crc_step(logic [CRC_W-1:0] c, logic [WORD_W-1:0] d);
    logic fb;
    for (int i = 0; i < WORD_W; i++) begin
      fb = c[CRC_W-1] ^ d[i];
      c  = {c[CRC_W-2:0], 1'b0};
      if (fb) c = c ^ 16'h1021;
    end
    return c;
  endfunction

  function automatic logic [WORD_W-1:0] par_word(logic [7:0] b);
    return {~(^b), ^b, b};
  endfunction

  function automatic logic [WORD_W-1:0] pkt_body(
    logic [IDX_W-1:0] idx, logic [CRC_W-1:0] ap, logic ap_v,
    logic [CRC_W-1:0] ff, logic ff_v, logic [14:0] fl);
    case (idx)
      5'd0:    return 10'h000;
      5'd1,
      5'd2:    return 10'h3FF;
      5'd3:    return DID_W;
      5'd4:    return DBN_W;
      5'd5:    return DC_W;
      5'd6:    return par_word({ap[5:0], 2'b00});
      5'd7:    return par_word({ap[11:6], 2'b00});
      5'd8:    return par_word({ap_v, 1'b0, ap[15:12], 2'b00});
      5'd9:    return par_word({ff[5:0], 2'b00});
      5'd10:   return par_word({ff[11:6], 2'b00});
      5'd11:   return par_word({ff_v, 1'b0, ff[15:12], 2'b00});
      5'd12:   return par_word({1'b0, fl[14:10], 2'b00});
      5'd13:   return par_word({1'b0, fl[9:5], 2'b00});
      5'd14:   return par_word({1'b0, fl[4:0], 2'b00});
      default: return RSV_W;
    endcase
  endfunction
endpackage

// File: rtl/edh_crc.sv
module edh_crc
  import edh_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              vld_i,
  input  logic              win_i,
  input  logic              fend_i,
  input  logic [WORD_W-1:0] data_i,
  output logic [CRC_W-1:0]  crc_o,
  output logic              valid_o
);
  logic [CRC_W-1:0] run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q   <= '0;
      crc_o   <= '0;
      valid_o <= 1'b0;
    end else if (fend_i) begin
      crc_o   <= run_q;
      valid_o <= 1'b1;
      run_q   <= '0;
    end else if (vld_i && win_i) begin
      run_q <= crc_step(run_q, data_i);
    end
  end
endmodule

// File: rtl/edh_flag_rx.sv
module edh_flag_rx
  import edh_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              vld_i,
  input  logic [WORD_W-1:0] data_i,
  output logic [14:0]       flags_o
);
  logic [WORD_W-1:0] h0_q, h1_q, h2_q;
  logic              act_q;
  logic [3:0]        cnt_q;
  logic              hdr_hit;

  assign hdr_hit = (h2_q == 10'h000) && (h1_q == 10'h3FF) && (h0_q == 10'h3FF) && (data_i == DID_W);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      h0_q <= '0; h1_q <= '0; h2_q <= '0;
      act_q <= 1'b0; cnt_q <= '0; flags_o <= '0;
    end else if (vld_i) begin
      h2_q <= h1_q; h1_q <= h0_q; h0_q <= data_i;
      if (hdr_hit) begin
        act_q <= 1'b1;
        cnt_q <= 4'd1;
      end else if (act_q) begin
        cnt_q <= cnt_q + 4'd1;
        case (cnt_q)
          4'd9:  flags_o[14:10] <= data_i[6:2];
          4'd10: flags_o[9:5]   <= data_i[6:2];
          4'd11: begin
            flags_o[4:0] <= data_i[6:2];
            act_q        <= 1'b0;
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/edh_pkt_gen.sv
module edh_pkt_gen
  import edh_pkg::*;
(
  input  logic [IDX_W-1:0]  idx_i,
  input  logic [CRC_W-1:0]  ap_crc_i,
  input  logic              ap_v_i,
  input  logic [CRC_W-1:0]  ff_crc_i,
  input  logic              ff_v_i,
  input  logic [14:0]       flags_i,
  output logic [WORD_W-1:0] word_o
);
  logic [8:0]        sum;
  logic [WORD_W-1:0] body;

  always_comb begin
    sum = '0;
    for (int i = 3; i < PKT_LEN - 1; i++) begin
      body = pkt_body(IDX_W'(i), ap_crc_i, ap_v_i, ff_crc_i, ff_v_i, flags_i);
      sum  = sum + body[8:0];
    end
    if (idx_i == IDX_W'(PKT_LEN - 1)) word_o = {~sum[8], sum};
    else word_o = pkt_body(idx_i, ap_crc_i, ap_v_i, ff_crc_i, ff_v_i, flags_i);
  end
endmodule

// File: rtl/edh_inserter.sv
module edh_inserter
  import edh_pkg::*;
#(
  parameter int HW = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              vld_i,
  input  logic [9:0]        data_i,
  input  logic [HW-1:0]     hcnt_i,
  input  logic [HW-1:0]     sav_pos_i,
  input  logic              ins_line_i,
  input  logic              ff_win_i,
  input  logic              ap_win_i,
  input  logic              field_end_i,
  input  logic              proc_en_i,
  input  logic              bypass_i,
  input  logic              sd_sel_i,
  input  logic              ins_dis_i,
  input  logic              upd_mode_i,
  input  logic [4:0]        anc_flags_i,
  input  logic [4:0]        ff_flags_i,
  input  logic [4:0]        ap_flags_i,
  output logic [9:0]        data_o,
  output logic              vld_o,
  output logic [14:0]       flags_o
);
  localparam int NCRC = 2;  // 0: active picture, 1: full field

  logic [NCRC-1:0]  win;
  logic [CRC_W-1:0] crc   [NCRC];
  logic [NCRC-1:0]  crc_v;
  logic [14:0]      rx_flags;
  logic [HW-1:0]    off;
  logic             en, ins;
  logic [WORD_W-1:0] pkt_word;

  assign win = {ff_win_i, ap_win_i};

  for (genvar g = 0; g < NCRC; g++) begin : g_crc
    edh_crc u_crc (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .vld_i  (vld_i),
      .win_i  (win[g]),
      .fend_i (field_end_i),
      .data_i (data_i),
      .crc_o  (crc[g]),
      .valid_o(crc_v[g])
    );
  end

  edh_flag_rx u_rx (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .vld_i  (vld_i),
    .data_i (data_i),
    .flags_o(rx_flags)
  );

  assign flags_o = upd_mode_i ? rx_flags : {anc_flags_i, ff_flags_i, ap_flags_i};

  // packet end is anchored one sample before SAV
  assign off = hcnt_i - (sav_pos_i - HW'(PKT_LEN));
  assign en  = proc_en_i & bypass_i & sd_sel_i & ~ins_dis_i;
  assign ins = vld_i & ins_line_i & en & (off < HW'(PKT_LEN));

  edh_pkt_gen u_gen (
    .idx_i   (off[IDX_W-1:0]),
    .ap_crc_i(crc[0]),
    .ap_v_i  (crc_v[0]),
    .ff_crc_i(crc[1]),
    .ff_v_i  (crc_v[1]),
    .flags_i (flags_o),
    .word_o  (pkt_word)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_o <= '0;
      vld_o  <= 1'b0;
    end else begin
      data_o <= ins ? pkt_word : data_i;
      vld_o  <= vld_i;
    end
  end
endmodule

// File: rtl/edh_inserter_chk.sv
module edh_inserter_chk #(
  parameter int HW = 12
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          vld_i,
  input logic [9:0]    data_i,
  input logic [HW-1:0] hcnt_i,
  input logic [HW-1:0] sav_pos_i,
  input logic          ins_line_i,
  input logic          proc_en_i,
  input logic          bypass_i,
  input logic          sd_sel_i,
  input logic          ins_dis_i,
  input logic [9:0]    data_o,
  input logic          vld_o
);
  logic past_ok;
  logic en_c;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) past_ok <= 1'b0;
    else         past_ok <= 1'b1;
  end

  assign en_c = proc_en_i && bypass_i && sd_sel_i && !ins_dis_i;

  assert_vld_delay_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok |-> vld_o == $past(vld_i));

  assert_other_lines_pass_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok && $past(!ins_line_i) |-> data_o == $past(data_i));

  assert_disabled_pass_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok && $past(!en_c) |-> data_o == $past(data_i));

  assert_sav_untouched_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok && $past(hcnt_i == sav_pos_i) |-> data_o == $past(data_i));

  assert_first_word_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok && $past(vld_i && ins_line_i && en_c && hcnt_i == sav_pos_i - HW'(23))
    |-> data_o == 10'h000);

  assert_checksum_b9_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok && $past(vld_i && ins_line_i && en_c && hcnt_i == sav_pos_i - HW'(1))
    |-> data_o[9] != data_o[8]);
endmodule

bind edh_inserter edh_inserter_chk #(.HW(HW)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .vld_i     (vld_i),
  .data_i    (data_i),
  .hcnt_i    (hcnt_i),
  .sav_pos_i (sav_pos_i),
  .ins_line_i(ins_line_i),
  .proc_en_i (proc_en_i),
  .bypass_i  (bypass_i),
  .sd_sel_i  (sd_sel_i),
  .ins_dis_i (ins_dis_i),
  .data_o    (data_o),
  .vld_o     (vld_o)
);

// File: tb/edh_inserter_bench.sv
module edh_inserter_bench;
  localparam int CLK_PERIOD = 10;
  localparam int HW   = 12;
  localparam int LLEN = 64;
  localparam int SAV  = 40;
  localparam int PSTART = SAV - 23;

  logic clk = 0, rst_n = 0;
  logic vld = 0, ins_line = 0, ff_win = 0, ap_win = 0, fend = 0;
  logic proc_en = 1, bypass = 1, sd_sel = 1, ins_dis = 0, upd = 0;
  logic [9:0] din = 0;
  logic [HW-1:0] hcnt = 0, sav_pos = HW'(SAV);
  logic [4:0] anc_f = 0, ff_f = 0, ap_f = 0;
  logic [9:0] dout;
  logic vld_out;
  logic [14:0] flags;

  int n_chk = 0, n_fail = 0;
  logic [15:0] m_ap = 0, m_ff = 0, h_ap = 0, h_ff = 0;
  logic h_v = 0;
  logic [9:0] exp_pkt [0:22];

  always #(CLK_PERIOD/2) clk = ~clk;

  edh_inserter #(.HW(HW)) u_edh_inserter (
    .clk_i(clk), .rst_ni(rst_n), .vld_i(vld), .data_i(din), .hcnt_i(hcnt),
    .sav_pos_i(sav_pos), .ins_line_i(ins_line), .ff_win_i(ff_win), .ap_win_i(ap_win),
    .field_end_i(fend), .proc_en_i(proc_en), .bypass_i(bypass), .sd_sel_i(sd_sel),
    .ins_dis_i(ins_dis), .upd_mode_i(upd), .anc_flags_i(anc_f), .ff_flags_i(ff_f),
    .ap_flags_i(ap_f), .data_o(dout), .vld_o(vld_out), .flags_o(flags)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] m_crc(logic [15:0] c, logic [9:0] d);
    for (int i = 0; i < 10; i++) begin
      logic top = c[15] ^ d[i];
      c = c << 1;
      if (top) c = c ^ 16'h1021;
    end
    return c;
  endfunction

  function automatic logic [9:0] m_par(logic [7:0] p);
    logic b8 = ^p;
    return {!b8, b8, p};
  endfunction

  function automatic logic [9:0] m_flagw(logic [4:0] f);
    return m_par({1'b0, f, 2'b00});
  endfunction

  function automatic logic [9:0] pat(int seed, int line, int hc);
    return 10'(((seed * 97 + line * 37 + hc * 11) % 1000) + 10);
  endfunction

  function automatic string tag_of(int k, string ftag);
    if (k == 22) return "R12";
    if (k >= 6 && k <= 11) return "R6 R7 R8 R11";
    if (k >= 12 && k <= 14) return ftag;
    return "R4 R5";
  endfunction

  // expected packet from latched model CRCs and the chosen flags {anc,ff,ap}
  task automatic build_pkt(input logic [14:0] fl);
    logic [8:0] s;
    exp_pkt[0] = 10'h000; exp_pkt[1] = 10'h3FF; exp_pkt[2] = 10'h3FF;
    exp_pkt[3] = 10'h1F4; exp_pkt[4] = 10'h200; exp_pkt[5] = 10'h110;
    exp_pkt[6]  = m_par({h_ap[5:0], 2'b00});
    exp_pkt[7]  = m_par({h_ap[11:6], 2'b00});
    exp_pkt[8]  = m_par({h_v, 1'b0, h_ap[15:12], 2'b00});
    exp_pkt[9]  = m_par({h_ff[5:0], 2'b00});
    exp_pkt[10] = m_par({h_ff[11:6], 2'b00});
    exp_pkt[11] = m_par({h_v, 1'b0, h_ff[15:12], 2'b00});
    exp_pkt[12] = m_flagw(fl[14:10]);
    exp_pkt[13] = m_flagw(fl[9:5]);
    exp_pkt[14] = m_flagw(fl[4:0]);
    for (int k = 15; k < 22; k++) exp_pkt[k] = 10'h200;
    s = 0;
    for (int k = 3; k < 22; k++) s = s + exp_pkt[k][8:0];
    exp_pkt[22] = {~s[8], s};
  endtask

  // one field of 4 lines; line 3 is the insertion line
  task automatic run_field(input int seed, input bit send_pkt, input logic [14:0] in_fl,
                           input logic [14:0] ins_fl, input bit expect_ins, input string ftag);
    build_pkt(ins_fl);
    for (int ln = 0; ln < 4; ln++) begin
      for (int hc = 0; hc < LLEN; hc++) begin
        logic [9:0] d, e;
        string t;
        if (hc == SAV) d = 10'h3FF;
        else if (hc == SAV + 1 || hc == SAV + 2) d = 10'h000;
        else if (hc == SAV + 3) d = 10'h200;
        else if (ln == 0 && send_pkt && hc >= 44 && hc <= 58) begin
          case (hc)
            44: d = 10'h000;
            45, 46: d = 10'h3FF;
            47: d = 10'h1F4;
            48: d = 10'h200;
            49: d = 10'h110;
            56: d = m_flagw(in_fl[14:10]);
            57: d = m_flagw(in_fl[9:5]);
            58: d = m_flagw(in_fl[4:0]);
            default: d = 10'h200;
          endcase
        end else d = pat(seed, ln, hc);
        @(negedge clk);
        vld = 1; din = d; hcnt = HW'(hc); ins_line = (ln == 3);
        ff_win = (hc < 36); ap_win = (ln == 1 || ln == 2) && hc >= 8 && hc < 32; fend = 0;
        @(posedge clk);
        #1;
        if (ln == 3 && expect_ins && hc >= PSTART && hc < SAV) begin
          e = exp_pkt[hc - PSTART]; t = tag_of(hc - PSTART, ftag);
        end else begin
          e = d; t = expect_ins ? "R2 R4" : "R3";
        end
        chk(dout === e, t, 32'(dout), 32'(e));
        if (ff_win) m_ff = m_crc(m_ff, d);
        if (ap_win) m_ap = m_crc(m_ap, d);
      end
    end
    @(negedge clk);
    vld = 0; ins_line = 0; ff_win = 1; ap_win = 1; fend = 1; din = 10'h155;
    @(posedge clk);
    #1;
    chk(vld_out === 1'b0, "R2", 32'(vld_out), 0);
    h_ap = m_ap; h_ff = m_ff; h_v = 1; m_ap = 0; m_ff = 0;
    @(negedge clk);
    fend = 0; ff_win = 0; ap_win = 0;
  endtask

  task automatic test_reset();
    #1;
    chk(dout === 10'h000, "R1 data_o", 32'(dout), 0);
    chk(vld_out === 1'b0, "R1 vld_o", 32'(vld_out), 0);
  endtask

  task automatic test_host_flags();
    upd = 0; anc_f = 5'h03; ff_f = 5'h10; ap_f = 5'h0A;
    #1 chk(flags === 15'h0E0A, "R9 flags_o", 32'(flags), 32'h0E0A);
    // first field after reset: zero CRCs with valid clear (R1)
    run_field(1, 0, 0, {anc_f, ff_f, ap_f}, 1, "R1 R8 R9 R11");
    anc_f = 5'h1F; ff_f = 5'h00; ap_f = 5'h15;
    run_field(2, 0, 0, {anc_f, ff_f, ap_f}, 1, "R9 R11");
  endtask

  task automatic test_pass_flags();
    upd = 1;
    run_field(3, 1, 15'h4C65, 15'h4C65, 1, "R10 R11");
    chk(flags === 15'h4C65, "R10 flags_o", 32'(flags), 32'h4C65);
    run_field(4, 1, 15'h13A9, 15'h13A9, 1, "R10 R11");
    chk(flags === 15'h13A9, "R10 flags_o", 32'(flags), 32'h13A9);
  endtask

  task automatic test_disabled();
    upd = 0;
    ins_dis = 1;
    run_field(5, 0, 0, 0, 0, "R3");
    ins_dis = 0; sd_sel = 0;
    run_field(6, 0, 0, 0, 0, "R3");
    sd_sel = 1; bypass = 0;
    run_field(7, 0, 0, 0, 0, "R3");
    bypass = 1;
    // CRCs kept running while disabled (R6)
    run_field(8, 0, 0, {anc_f, ff_f, ap_f}, 1, "R6 R9");
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=running expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    test_reset();
    @(negedge clk) rst_n = 1;
    test_host_flags();
    test_pass_flags();
    test_disabled();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end
endmodule